// File: doc/BRIEF.md
# Radix-4 Signed-Digit Partial Product Generator

This block forms one partial product of a radix-4 signed-digit multiplier. It multiplies a multiplicand of `N` signed digits by a single signed digit and returns the product in the same signed-digit form. Each digit takes a value from -3 to +3. There is no ripple carry across the word, so the depth of the logic does not grow with `N`.

The circuit is purely combinational. One small multiply cell per multiplicand digit turns a digit pair into a bounded product digit and a carry. A two-stage signed-digit adder then merges each cell's product digit with the carry of the cell one position below. The result has `N+2` digits. A multiplier that loops over the multiplier digits, or a tree of these generators, takes the result and shifts it into place.

Top module: `qsd_pp_gen`

## Requirements
- R1: Every digit is a 3-bit two's-complement field holding a value in -3..+3. Digit i of a vector sits at bits [3i+2:3i] and weighs 4^i. Digit -1 is coded 3'b111 and digit -3 is coded 3'b101.
- R2: For every valid multiplicand and multiplier digit, the value of the result equals the value of the multiplicand times the value of the multiplier digit.
- R3: Each cell splits the product p of its two digits into p = 4*C + M, with |M| <= 2 and |C| <= 2.
- R4: A cell carry has magnitude 2 only when |p| = 9. Such a split is (C, M) = (2, 1) for p = 9 and (-2, -1) for p = -9.
- R5: The cell splits for the other products are as follows, with negative products mirrored: p = 6 gives (C, M) = (1, 2); p = 4 gives (1, 0); p = 3 gives (1, -1); |p| <= 2 gives (0, p). When only multiplicand digit 0 is non-zero, result digit 0 is M, result digit 1 is C, and all other result digits are 0.
- R6: Every result digit, the top one included, lies in -3..+3. The code 3'b100 never appears.
- R7: A zero multiplier digit gives a result in which every digit is zero.
- R8: In the gatherer, when the first-stage sum s at a position has |s| >= 3, that position passes an intermediate carry of sign(s) to the next position up and keeps s - 4*sign(s). Smaller sums pass no carry. The carry out of position N becomes result digit N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand | input | 3*N | Multiplicand, N signed digits, digit 0 in the low bits |
| mdig | input | 3 | Multiplier digit, -3..+3 |
| pprod | output | 3*(N+2) | Partial product, N+2 signed digits |

## Verification
A wrong split inside a multiply cell shows at the ports right away. A multiplicand with only its low digit set brings that cell's product digit and carry straight out as result digits 0 and 1, so each split can be compared digit by digit. A wrong intermediate carry or kept sum in the gatherer changes the value of the result in the same evaluation. A wrong carry at the top position also changes the value, and it can push a digit outside -3..+3. The bench therefore compares exact digit patterns for the hand-worked cases, and checks the value and the digit range over every multiplicand and multiplier combination.

// File: rtl/qsd_pp_pkg.sv
package qsd_pp_pkg;

  localparam int DIG_W = 3;

  typedef logic signed [DIG_W-1:0] qdig_t;

  // true when a 3-bit code holds a legal digit (-3..+3)
  function automatic logic qdig_ok(input qdig_t d);
    return d != 3'sb100;
  endfunction

  // carry taken out of a single-digit product so that the kept part fits in -2..+2
  function automatic int prod_carry(input int p);
    int mag;
    int cy;
    mag = (p < 0) ? -p : p;
    if (mag >= 9)      cy = 2;
    else if (mag >= 3) cy = 1;
    else               cy = 0;
    return (p < 0) ? -cy : cy;
  endfunction

  // intermediate carry of the gatherer's first stage
  function automatic int sum_carry(input int s);
    if (s >= 3)  return 1;
    if (s <= -3) return -1;
    return 0;
  endfunction

endpackage

// File: rtl/qsd_digit_mul.sv
module qsd_digit_mul
  import qsd_pp_pkg::*;
(
  input  qdig_t a_dig,
  input  qdig_t b_dig,
  output qdig_t prod_m,
  output qdig_t prod_c
);

  int prod_full;
  int carry_int;

  always_comb begin
    prod_full = int'(a_dig) * int'(b_dig);
    carry_int = prod_carry(prod_full);
    prod_c    = qdig_t'(carry_int);
    prod_m    = qdig_t'(prod_full - 4 * carry_int);
  end

  always_comb begin
    if (qdig_ok(a_dig) && qdig_ok(b_dig)) begin
      AST_CELL_RECOMBINE: assert (4 * int'(prod_c) + int'(prod_m) == int'(a_dig) * int'(b_dig)); // R3
      AST_CELL_M_BOUND: assert (prod_m >= -2 && prod_m <= 2); // R3
      AST_CELL_C_BOUND: assert (prod_c >= -2 && prod_c <= 2); // R3
      AST_CELL_C2_AT9: assert (!(prod_c == 2 || prod_c == -2) || (int'(a_dig) * int'(b_dig) == 9 || int'(a_dig) * int'(b_dig) == -9)); // R4
    end
  end

endmodule

// File: rtl/qsd_sum_split.sv
module qsd_sum_split
  import qsd_pp_pkg::*;
(
  input  qdig_t             x_dig,
  input  qdig_t             y_dig,
  output logic signed [1:0] mid_carry,
  output qdig_t             mid_sum
);

  int raw_sum;
  int cy;

  always_comb begin
    raw_sum   = int'(x_dig) + int'(y_dig);
    cy        = sum_carry(raw_sum);
    mid_carry = 2'(cy);
    mid_sum   = qdig_t'(raw_sum - 4 * cy);
  end

  always_comb begin
    if (qdig_ok(x_dig) && qdig_ok(y_dig)) begin
      AST_MID_SUM_BOUND: assert (mid_sum >= -2 && mid_sum <= 2); // R8
      AST_MID_CARRY_LEGAL: assert (mid_carry != 2'sb10); // R8
      AST_MID_RECOMBINE: assert (4 * int'(mid_carry) + int'(mid_sum) == int'(x_dig) + int'(y_dig)); // R8
    end
  end

endmodule

// File: rtl/qsd_gather.sv
module qsd_gather
  import qsd_pp_pkg::*;
#(
  parameter int ND = 5
) (
  input  logic [DIG_W*ND-1:0]     x_vec,
  input  logic [DIG_W*ND-1:0]     y_vec,
  output logic [DIG_W*(ND+1)-1:0] s_vec
);

  localparam int SW = DIG_W * (ND + 1);

  logic signed [1:0] mid_carry [ND];
  qdig_t             mid_sum   [ND];
  qdig_t             fin_dig   [ND+1];

  for (genvar i = 0; i < ND; i++) begin : g_split
    qsd_sum_split u_split (
      .x_dig    (qdig_t'(x_vec[DIG_W*i +: DIG_W])),
      .y_dig    (qdig_t'(y_vec[DIG_W*i +: DIG_W])),
      .mid_carry(mid_carry[i]),
      .mid_sum  (mid_sum[i])
    );
  end

  // second stage: kept sum plus the carry from one position below
  assign fin_dig[0] = mid_sum[0];
  for (genvar i = 1; i < ND; i++) begin : g_absorb
    assign fin_dig[i] = qdig_t'(int'(mid_sum[i]) + int'(mid_carry[i-1]));
  end
  assign fin_dig[ND] = qdig_t'(int'(mid_carry[ND-1]));

  for (genvar i = 0; i <= ND; i++) begin : g_pack
    assign s_vec[DIG_W*i +: DIG_W] = fin_dig[i];
  end

  always_comb begin
    for (int i = 0; i <= ND; i++) begin
      AST_FINAL_DIGIT_RANGE: assert (s_vec[DIG_W*i +: DIG_W] != 3'b100); // R6
    end
  end

  logic unused_ok;
  assign unused_ok = ^{SW};

endmodule

// File: rtl/qsd_pp_gen.sv
module qsd_pp_gen
  import qsd_pp_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [DIG_W*N-1:0]     mcand,
  input  logic [DIG_W-1:0]       mdig,
  output logic [DIG_W*(N+2)-1:0] pprod
);

  localparam int GD = N + 1;

  qdig_t               cell_m [N];
  qdig_t               cell_c [N];
  logic [DIG_W*GD-1:0] addend_m;
  logic [DIG_W*GD-1:0] addend_c;

  for (genvar i = 0; i < N; i++) begin : g_cell
    qsd_digit_mul u_cell (
      .a_dig (qdig_t'(mcand[DIG_W*i +: DIG_W])),
      .b_dig (qdig_t'(mdig)),
      .prod_m(cell_m[i]),
      .prod_c(cell_c[i])
    );
    assign addend_m[DIG_W*i +: DIG_W]     = cell_m[i];
    assign addend_c[DIG_W*(i+1) +: DIG_W] = cell_c[i];
  end
  assign addend_m[DIG_W*N +: DIG_W] = '0;
  assign addend_c[0 +: DIG_W]       = '0;

  qsd_gather #(.ND(GD)) u_gather (
    .x_vec(addend_m),
    .y_vec(addend_c),
    .s_vec(pprod)
  );

  logic in_ok;
  longint mc_val;
  longint pp_val;

  always_comb begin
    in_ok  = qdig_ok(qdig_t'(mdig));
    mc_val = 0;
    pp_val = 0;
    for (int i = N - 1; i >= 0; i--) begin
      in_ok  = in_ok && qdig_ok(qdig_t'(mcand[DIG_W*i +: DIG_W]));
      mc_val = mc_val * 4 + longint'(qdig_t'(mcand[DIG_W*i +: DIG_W]));
    end
    for (int i = N + 1; i >= 0; i--) begin
      pp_val = pp_val * 4 + longint'(qdig_t'(pprod[DIG_W*i +: DIG_W]));
    end
    if (in_ok) begin
      AST_PRODUCT_VALUE: assert (pp_val == mc_val * longint'(qdig_t'(mdig))); // R2
      AST_ZERO_MULT: assert (mdig != 3'b000 || pprod == '0); // R7
    end
  end

endmodule

// File: tb/sim_qsd_pp_gen.sv
module sim_qsd_pp_gen;

  localparam int ND = 4;
  localparam int RD = ND + 2;

  typedef struct {
    logic [3*ND-1:0] mc;
    logic [2:0]      md;
    longint          exp_val;
    bit              chk_dig;
    logic [3*RD-1:0] exp_dig;
    string           tag;
  } sb_item_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [3*ND-1:0] mcand = '0;
  logic [2:0]      mdig  = '0;
  logic [3*RD-1:0] pprod;

  qsd_pp_gen #(.N(ND)) u0 (.mcand(mcand), .mdig(mdig), .pprod(pprod));

  sb_item_t sbq[$];
  int n_chk  = 0;
  int n_bad  = 0;
  bit done   = 1'b0;
  int cycles = 0;

  // value of a vector of signed digits, read from the high end
  function automatic longint vec_value(input logic [3*RD-1:0] v, input int nd);
    longint acc = 0;
    for (int k = nd - 1; k >= 0; k--) begin
      logic signed [2:0] d = v[3*k +: 3];
      acc = acc * 4 + longint'(d);
    end
    return acc;
  endfunction

  function automatic logic [3*RD-1:0] dig6(input int d0, d1, d2, d3, d4, d5);
    logic [3*RD-1:0] v;
    v = {3'(d5), 3'(d4), 3'(d3), 3'(d2), 3'(d1), 3'(d0)};
    return v;
  endfunction

  task automatic drive(input logic [3*ND-1:0] mc, input logic [2:0] md,
                       input bit chk, input logic [3*RD-1:0] ed, input string tag);
    sb_item_t it;
    @(posedge clk);
    mcand = mc;
    mdig  = md;
    it.mc      = mc;
    it.md      = md;
    it.exp_val = vec_value({6'b0, mc}, ND) * longint'($signed(md));
    it.chk_dig = chk;
    it.exp_dig = ed;
    it.tag     = tag;
    sbq.push_back(it);
  endtask

  // monitor: compares away from the edge where inputs move
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      sb_item_t it;
      longint act;
      bit rng_ok;
      it  = sbq.pop_front();
      act = vec_value(pprod, RD);
      n_chk++;
      if (act !== it.exp_val) begin
        n_bad++;
        $display("FAIL R2 %s mc=%h md=%0d value actual %0d expected %0d", it.tag, it.mc, $signed(it.md), act, it.exp_val);
      end
      rng_ok = 1'b1;
      for (int k = 0; k < RD; k++) if (pprod[3*k +: 3] == 3'b100) rng_ok = 1'b0;
      n_chk++;
      if (!rng_ok) begin
        n_bad++;
        $display("FAIL R6 %s digit code 100 present: actual %h expected no such digit", it.tag, pprod);
      end
      if (it.chk_dig) begin
        n_chk++;
        if (pprod !== it.exp_dig) begin
          n_bad++;
          $display("FAIL %s digits actual %h expected %h", it.tag, pprod, it.exp_dig);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // reset state: inputs at zero give an all-zero result (R7)
    #2;
    n_chk++;
    if (pprod !== '0) begin
      n_bad++;
      $display("FAIL R7 initial result actual %h expected 0", pprod);
    end
    // R5 / R3 / R4: single low digit exposes the cell split as digits 0 and 1
    drive(12'(3'sd3),  3'sd3,  1, dig6( 1,  2, 0, 0, 0, 0), "R4 p=9");
    drive(12'(-3'sd3) & 12'h7, 3'sd3, 1, dig6(-1, -2, 0, 0, 0, 0), "R4 p=-9");
    drive(12'(3'sd2),  3'sd3,  1, dig6( 2,  1, 0, 0, 0, 0), "R5 p=6");
    drive(12'(3'sd2),  -3'sd3, 1, dig6(-2, -1, 0, 0, 0, 0), "R5 p=-6");
    drive(12'(3'sd2),  3'sd2,  1, dig6( 0,  1, 0, 0, 0, 0), "R5 p=4");
    drive(12'h5,       3'sd1,  1, dig6( 1, -1, 0, 0, 0, 0), "R5 p=-3");
    drive(12'(3'sd1),  3'sd3,  1, dig6(-1,  1, 0, 0, 0, 0), "R3 p=3");
    drive(12'(3'sd1),  -3'sd2, 1, dig6(-2,  0, 0, 0, 0, 0), "R5 p=-2");
    // R8: first-stage sum of 4 at position 1 carries into position 2
    drive({3'd0, 3'd0, 3'd2, 3'd3}, 3'sd3, 1, dig6( 1, 0,  2, 0, 0, 0), "R8 carry");
    drive({3'd0, 3'd0, 3'b110, 3'b101}, 3'sd3, 1, dig6(-1, 0, -2, 0, 0, 0), "R8 mirrored");
    // R8 / R6: all-3 multiplicand, top digit reaches 3
    drive({3'd3, 3'd3, 3'd3, 3'd3}, 3'sd3, 1, dig6( 1, -1, 0, 0, 3, 0), "R8 R6 top");
    // R7: zero multiplier
    drive({3'd3, 3'b101, 3'd2, 3'b111}, 3'd0, 1, '0, "R7 zero");
    // R1 R2: every valid multiplicand and multiplier digit
    for (int b = -3; b <= 3; b++) begin
      for (int a = 0; a < 2401; a++) begin
        logic [3*ND-1:0] mc;
        int r = a;
        for (int k = 0; k < ND; k++) begin
          mc[3*k +: 3] = 3'((r % 7) - 3);
          r = r / 7;
        end
        drive(mc, 3'(b), 0, '0, "R1 R2 sweep");
      end
    end
    while (sbq.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule